// File: doc/BRIEF.md
# Conditional Branch Resolver with Immediate Comparand

This block is a purely combinational branch decode and resolve stage for a 32-bit integer core. It inspects the instruction word and, when it finds a conditional branch, evaluates the branch condition on the register operands and forms the branch target from the current PC. It produces a valid-branch flag, an illegal-instruction flag, the taken decision, the target address, and a hint that the second register port is not needed.

Besides the six register-register conditions, two compare-with-immediate forms use the funct3 codes that the base branch class leaves free. In these forms the field at bits [24:20] normally used as the second register index instead carries a small constant. A field of zero means minus one, and 1 to 31 stand for themselves. The register file can skip the second read for them. A parameter removes the immediate forms, and their codes then decode as illegal.

Top module: `bci_branch_unit`

## Requirements
- R1: Only inst[6:0] = 1100011 is treated as a branch. For any other opcode, br_valid_o, illegal_o, taken_o and rs2_unused_o are all 0.
- R2: funct3 000 tests rs1 == rs2 and 001 tests rs1 != rs2. 100 tests signed rs1 < rs2 and 101 tests signed rs1 >= rs2. 110 tests unsigned rs1 < rs2 and 111 tests unsigned rs1 >= rs2.
- R3: With IMM_EN = 1, funct3 010 is taken when rs1 equals the immediate comparand, and 011 is taken when they differ. rs2_i has no effect on any output of these forms.
- R4: The comparand comes from inst[24:20]. A value of 0 gives all-ones (-1), and values 1 to 31 are zero-extended.
- R5: rs2_unused_o is 1 exactly when br_valid_o is 1 and funct3 is 010 or 011.
- R6: target_o = pc_i + sign-extended {inst[31], inst[7], inst[30:25], inst[11:8], 0}. This covers offsets from -4096 to +4094.
- R7: taken_o is 1 only when br_valid_o is 1 and the selected condition holds.
- R8: With IMM_EN = 0, a branch opcode with funct3 010 or 011 sets illegal_o = 1. In that case br_valid_o, taken_o and rs2_unused_o are 0. illegal_o is never 1 together with br_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst_i | input | 32 | Instruction word |
| pc_i | input | XLEN | Address of the instruction |
| rs1_i | input | XLEN | First source register value |
| rs2_i | input | XLEN | Second source register value |
| br_valid_o | output | 1 | A legal conditional branch is decoded |
| illegal_o | output | 1 | Branch opcode with a funct3 that is disabled |
| taken_o | output | 1 | Branch condition holds |
| target_o | output | XLEN | PC plus B-type offset |
| rs2_unused_o | output | 1 | Immediate form; second register not read |

## Verification
The bench builds two copies side by side, one with IMM_EN = 1 and one with IMM_EN = 0, and applies every vector to both. The same instruction stream therefore shows funct3 010 and 011 being resolved as immediate compares in one copy and flagged as illegal in the other. Both copies use the default XLEN of 32. With that width the extreme signed operands, the all-ones comparand and both ends of the offset range are all reachable.

// File: rtl/bci_pkg.sv
package bci_pkg;

  localparam int unsigned ILEN = 32;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam int unsigned CMP_FIELD_W = 5;
  localparam int unsigned BOFF_W = 13;

  typedef enum logic [2:0] {
    F3_EQ  = 3'b000,
    F3_NE  = 3'b001,
    F3_EQI = 3'b010,
    F3_NEI = 3'b011,
    F3_LT  = 3'b100,
    F3_GE  = 3'b101,
    F3_LTU = 3'b110,
    F3_GEU = 3'b111
  } br_f3_e;

  typedef enum logic [1:0] {
    CMP_EQ  = 2'd0,
    CMP_LT  = 2'd1,
    CMP_LTU = 2'd2
  } cmp_kind_e;

  typedef struct packed {
    logic      valid;
    logic      illegal;
    logic      use_imm;
    cmp_kind_e kind;
    logic      negate;
  } br_ctl_t;

endpackage

// File: rtl/bci_decode.sv
module bci_decode
  import bci_pkg::*;
#(
  parameter bit IMM_EN = 1'b1
) (
  input  logic [ILEN-1:0] inst_i,
  output br_ctl_t         ctl_o
);

  logic   is_branch;
  br_f3_e f3;

  assign is_branch = (inst_i[6:0] == OPC_BRANCH);
  assign f3        = br_f3_e'(inst_i[14:12]);

  always_comb begin
    ctl_o = '0;
    if (is_branch) begin
      ctl_o.valid = 1'b1;
      unique case (f3)
        F3_EQ:  begin ctl_o.kind = CMP_EQ;  ctl_o.negate = 1'b0; end
        F3_NE:  begin ctl_o.kind = CMP_EQ;  ctl_o.negate = 1'b1; end
        F3_LT:  begin ctl_o.kind = CMP_LT;  ctl_o.negate = 1'b0; end
        F3_GE:  begin ctl_o.kind = CMP_LT;  ctl_o.negate = 1'b1; end
        F3_LTU: begin ctl_o.kind = CMP_LTU; ctl_o.negate = 1'b0; end
        F3_GEU: begin ctl_o.kind = CMP_LTU; ctl_o.negate = 1'b1; end
        F3_EQI, F3_NEI: begin
          ctl_o.kind   = CMP_EQ;
          ctl_o.negate = (f3 == F3_NEI);
          if (IMM_EN) begin
            ctl_o.use_imm = 1'b1;
          end else begin
            ctl_o.valid   = 1'b0;
            ctl_o.illegal = 1'b1;
          end
        end
        default: ctl_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/bci_operand.sv
module bci_operand
  import bci_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                   use_imm_i,
  input  logic [CMP_FIELD_W-1:0] field_i,
  input  logic [XLEN-1:0]        rs2_i,
  output logic [XLEN-1:0]        opnd_o
);

  localparam int unsigned PAD_W = XLEN - CMP_FIELD_W;

  logic [XLEN-1:0] imm_val;

  // Field zero is redundant with x0, so it encodes -1.
  always_comb begin
    if (field_i == '0) imm_val = '1;
    else               imm_val = {{PAD_W{1'b0}}, field_i};
  end

  assign opnd_o = use_imm_i ? imm_val : rs2_i;

endmodule

// File: rtl/bci_compare.sv
module bci_compare
  import bci_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  cmp_kind_e       kind_i,
  input  logic            negate_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            hit_o
);

  logic eq, lt_s, lt_u, raw;

  assign eq   = (a_i == b_i);
  assign lt_s = ($signed(a_i) < $signed(b_i));
  assign lt_u = (a_i < b_i);

  always_comb begin
    unique case (kind_i)
      CMP_LT:  raw = lt_s;
      CMP_LTU: raw = lt_u;
      default: raw = eq;
    endcase
  end

  assign hit_o = raw ^ negate_i;

endmodule

// File: rtl/bci_target.sv
module bci_target
  import bci_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [ILEN-1:0] inst_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] target_o
);

  localparam int unsigned EXT_W = XLEN - BOFF_W;

  logic [BOFF_W-1:0] boff;
  logic [XLEN-1:0]   boff_x;

  assign boff     = {inst_i[31], inst_i[7], inst_i[30:25], inst_i[11:8], 1'b0};
  assign boff_x   = {{EXT_W{boff[BOFF_W-1]}}, boff};
  assign target_o = pc_i + boff_x;

endmodule

// File: rtl/bci_branch_unit.sv
module bci_branch_unit
  import bci_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter bit          IMM_EN = 1'b1
) (
  input  logic [31:0]     inst_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic            br_valid_o,
  output logic            illegal_o,
  output logic            taken_o,
  output logic [XLEN-1:0] target_o,
  output logic            rs2_unused_o
);

  br_ctl_t         ctl;
  logic [XLEN-1:0] opnd;
  logic            hit;

  bci_decode #(.IMM_EN(IMM_EN)) u_decode (
    .inst_i (inst_i),
    .ctl_o  (ctl)
  );

  bci_operand #(.XLEN(XLEN)) u_operand (
    .use_imm_i (ctl.use_imm),
    .field_i   (inst_i[24:20]),
    .rs2_i     (rs2_i),
    .opnd_o    (opnd)
  );

  bci_compare #(.XLEN(XLEN)) u_compare (
    .kind_i   (ctl.kind),
    .negate_i (ctl.negate),
    .a_i      (rs1_i),
    .b_i      (opnd),
    .hit_o    (hit)
  );

  bci_target #(.XLEN(XLEN)) u_target (
    .inst_i   (inst_i),
    .pc_i     (pc_i),
    .target_o (target_o)
  );

  assign br_valid_o   = ctl.valid;
  assign illegal_o    = ctl.illegal;
  assign taken_o      = ctl.valid & hit;
  assign rs2_unused_o = ctl.valid & ctl.use_imm;

  always_comb begin
    if (!$isunknown({inst_i, pc_i, rs1_i, rs2_i})) begin
      a_r1_non_branch_quiet: assert (inst_i[6:0] == OPC_BRANCH ||
        {br_valid_o, illegal_o, taken_o, rs2_unused_o} == 4'b0000);
      a_r4_zero_field_all_ones: assert (!(rs2_unused_o && inst_i[24:20] == 5'd0) ||
        opnd == {XLEN{1'b1}});
      a_r5_imm_hint_matches_f3: assert (rs2_unused_o ==
        (br_valid_o && inst_i[14:13] == 2'b01));
      a_r6_target_lsb_follows_pc: assert (target_o[0] == pc_i[0]);
      a_r7_taken_needs_valid: assert (!taken_o || br_valid_o);
      a_r8_illegal_excludes_valid: assert (!(illegal_o && br_valid_o));
    end
  end

endmodule

// File: tb/bci_branch_unit_tb.sv
module bci_branch_unit_tb;

  localparam int XL = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] inst;
  logic [XL-1:0] pc, rs1, rs2;

  logic v1, il1, tk1, nu1;
  logic [XL-1:0] tg1;
  logic v0, il0, tk0, nu0;
  logic [XL-1:0] tg0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bci_branch_unit #(.XLEN(XL), .IMM_EN(1'b1)) u_dut (
    .inst_i(inst), .pc_i(pc), .rs1_i(rs1), .rs2_i(rs2),
    .br_valid_o(v1), .illegal_o(il1), .taken_o(tk1),
    .target_o(tg1), .rs2_unused_o(nu1)
  );

  bci_branch_unit #(.XLEN(XL), .IMM_EN(1'b0)) u_dut_noimm (
    .inst_i(inst), .pc_i(pc), .rs1_i(rs1), .rs2_i(rs2),
    .br_valid_o(v0), .illegal_o(il0), .taken_o(tk0),
    .target_o(tg0), .rs2_unused_o(nu0)
  );

  function automatic logic [31:0] mk_br(input logic [2:0] f3, input logic [4:0] fld,
                                        input logic [12:0] off);
    return {off[12], off[10:5], fld, 5'd1, f3, off[4:1], off[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] ref_imm(input logic [4:0] fld);
    return (fld == 5'd0) ? 32'hFFFF_FFFF : {27'd0, fld};
  endfunction

  task automatic model(input bit imm_en, output logic v, output logic il,
                       output logic tk, output logic [31:0] tg, output logic nu);
    logic [2:0] f3;
    logic c;
    f3 = inst[14:12];
    tg = pc + {{19{inst[31]}}, inst[31], inst[7], inst[30:25], inst[11:8], 1'b0};
    v = 0; il = 0; tk = 0; nu = 0; c = 0;
    if (inst[6:0] == 7'b1100011) begin
      if (f3 == 3'b010 || f3 == 3'b011) begin
        if (imm_en) begin
          v = 1; nu = 1;
          c = (rs1 == ref_imm(inst[24:20])) ^ f3[0];
        end else il = 1;
      end else begin
        v = 1;
        case (f3)
          3'b000: c = rs1 == rs2;
          3'b001: c = rs1 != rs2;
          3'b100: c = $signed(rs1) < $signed(rs2);
          3'b101: c = $signed(rs1) >= $signed(rs2);
          3'b110: c = rs1 < rs2;
          default: c = rs1 >= rs2;
        endcase
      end
      tk = v & c;
    end
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s inst=%h rs1=%h rs2=%h actual=%h expected=%h",
               req, what, inst, rs1, rs2, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [31:0] i, input logic [31:0] p,
                       input logic [31:0] a, input logic [31:0] b);
    logic v, il, tk, nu;
    logic [31:0] tg;
    @(posedge clk);
    inst = i; pc = p; rs1 = a; rs2 = b;
    @(negedge clk);
    model(1'b1, v, il, tk, tg, nu);
    chk(req, "valid", {31'd0, v1}, {31'd0, v});
    chk(req, "illegal", {31'd0, il1}, {31'd0, il});
    chk(req, "taken", {31'd0, tk1}, {31'd0, tk});
    chk(req, "target", tg1, tg);
    chk(req, "rs2_unused", {31'd0, nu1}, {31'd0, nu});
    model(1'b0, v, il, tk, tg, nu);
    chk(req, "noimm.valid", {31'd0, v0}, {31'd0, v});
    chk(req, "noimm.illegal", {31'd0, il0}, {31'd0, il});
    chk(req, "noimm.taken", {31'd0, tk0}, {31'd0, tk});
    chk(req, "noimm.target", tg0, tg);
    chk(req, "noimm.rs2_unused", {31'd0, nu0}, {31'd0, nu});
  endtask

  // R1: idle and non-branch opcodes
  task automatic t_non_branch();
    apply("R1", 32'h0000_0000, 32'h100, 32'h5, 32'h5);
    apply("R1", 32'h0000_0013, 32'h100, 32'h0, 32'h0);
    apply("R1", mk_br(3'b000, 5'd2, 13'h10) ^ 32'h1, 32'h100, 32'h7, 32'h7);
    apply("R1", mk_br(3'b010, 5'd3, 13'h10) ^ 32'h40, 32'h100, 32'h3, 32'h3);
  endtask

  // R2 and R7: register-register conditions at signed/unsigned edges
  task automatic t_base_conds();
    logic [31:0] vals [5] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};
    foreach (vals[x]) begin
      foreach (vals[y]) begin
        for (int f = 0; f < 8; f++) begin
          if (f != 2 && f != 3)
            apply("R2", mk_br(3'(f), 5'd2, 13'h20), 32'h4000, vals[x], vals[y]);
        end
      end
    end
  endtask

  // R3, R4, R5: comparand corners -1, 1, 31; rs2 must not matter
  task automatic t_imm_corners();
    logic [4:0] flds [3] = '{5'd0, 5'd1, 5'd31};
    foreach (flds[k]) begin
      for (int f = 2; f < 4; f++) begin
        apply("R4", mk_br(3'(f), flds[k], 13'h8), 32'h200, ref_imm(flds[k]), 32'h0);
        apply("R3", mk_br(3'(f), flds[k], 13'h8), 32'h200, ref_imm(flds[k]),
              ref_imm(flds[k]) + 1);
        apply("R3", mk_br(3'(f), flds[k], 13'h8), 32'h200, ref_imm(flds[k]) ^ 32'h100,
              ref_imm(flds[k]) ^ 32'h100);
        apply("R5", mk_br(3'(f), flds[k], 13'h8), 32'h200, 32'h0, 32'hFFFF_FFFF);
      end
    end
    apply("R4", mk_br(3'b010, 5'd0, 13'h8), 32'h200, 32'h0000_001F, 32'h0);
    apply("R4", mk_br(3'b010, 5'd31, 13'h8), 32'h200, 32'hFFFF_FFFF, 32'h0);
  endtask

  // R6: offset range ends and wrap
  task automatic t_target();
    apply("R6", mk_br(3'b000, 5'd2, 13'h0FFE), 32'h0001_0000, 32'h1, 32'h1);
    apply("R6", mk_br(3'b000, 5'd2, 13'h1000), 32'h0001_0000, 32'h1, 32'h1);
    apply("R6", mk_br(3'b001, 5'd2, 13'h1FFE), 32'h0000_0000, 32'h1, 32'h2);
    apply("R6", mk_br(3'b011, 5'd5, 13'h0AAA), 32'hFFFF_FFF0, 32'h1, 32'h2);
  endtask

  // R8: codes 010/011 in the build without immediate forms
  task automatic t_disabled();
    for (int f = 2; f < 4; f++) begin
      apply("R8", mk_br(3'(f), 5'd0, 13'h40), 32'h800, 32'hFFFF_FFFF, 32'h0);
      apply("R8", mk_br(3'(f), 5'd9, 13'h40), 32'h800, 32'h1, 32'h9);
    end
  endtask

  task automatic t_random();
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] i, a, b;
      i = $urandom; a = $urandom; b = $urandom;
      if (n % 2 == 0) i[6:0] = 7'b1100011;
      if (n % 4 == 0) a = (i[14:13] == 2'b01) ? ref_imm(i[24:20]) : b;
      apply("R7", i, $urandom, a, b);
    end
  endtask

  initial begin
    inst = '0; pc = '0; rs1 = '0; rs2 = '0;
    repeat (3) @(posedge clk);
    apply("R1", 32'h0, 32'h0, 32'h0, 32'h0);
    rst_ni = 1'b1;
    t_non_branch();
    t_base_conds();
    t_imm_corners();
    t_target();
    t_disabled();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule